// File: doc/BRIEF.md
# Synchronous Burst Pseudo-SRAM Front End

This block sits in front of a small on-chip 16-bit word array. It behaves like the clocked command port of a pseudo-static RAM. On every rising clock edge it samples the chip select, address-valid strobe, write enable, configuration-select line, the two byte enables and the address. From these it decodes a burst start (read or write), a burst advance or no-operation cycle, a configuration load, or a deselect.

A configuration word sets the burst length and the latency to the first word. Read words leave through a data bus that is qualified by an output-enable flag. During a write burst, a WAIT flag holds the host off until the array is ready. A refresh request input stands in for the internal refresh. While a refresh is running, a write burst cannot leave its latency phase.

A second configuration word holds a deep-power-down bit. While that bit is set, every burst command is refused. Only another configuration load can clear the bit.

Top module: `psram_burst_front`

## Requirements
- R1: After reset, rdata_oe and wait_o are 0 and rdata is 0. The bus configuration word resets to 16'h1807, which means continuous burst with latency 3. The power control word resets to 0.
- R2: A configuration load happens on an edge with cs_n=0, adv_n=0, cre=1 while no burst is active. If addr[19]=1 it writes the bus configuration word, otherwise the power control word, with the value addr[15:0]. Bus configuration bits 2:0 select the length: 1 gives 4 words, 2 gives 8, 3 gives 16, and any other value is continuous. Bits 13:11 hold the latency L, clamped to the range 2..6.
- R3: A read start is an edge with cs_n=0, adv_n=0, cre=0, we_n=1. The first word appears with rdata_oe=1 after the L-th later advance edge. Each further advance edge gives the next word. An advance edge has cs_n=0, adv_n=1 and at least one byte enable active.
- R4: A fixed-length burst wraps within the block of N words that is aligned to N. A continuous burst counts up modulo the array depth. A fixed burst ends after N words, and rdata_oe then falls.
- R5: A write start (we_n=0) raises wait_o in the following cycle. With no refresh, wait_o falls after L-1 advance edges. The first wdata word is stored at the next advance edge, the L-th, and later words at the following advance edges.
- R6: A pulse on refresh_req keeps refresh busy for REF_CYCLES edges. Each advance edge of a write latency phase that meets a busy refresh does not count, so wait_o stays high one cycle longer.
- R7: ub_n gates byte lane 15:8 and lb_n gates lane 7:0. An inactive lane is not written, and it reads as 0. An edge with cs_n=0 and both enables inactive acts as a deselect.
- R8: An edge with cs_n=1 ends any burst. In the next cycle rdata_oe=0 and wait_o=0.
- R9: A configuration load during a burst changes no register. That edge neither advances nor ends the burst.
- R10: Advance or no-operation edges (cs_n=0, adv_n=1) while idle leave the outputs and the registers unchanged.
- R11: While power control bit 4 is 1, burst starts are ignored and rdata_oe and wait_o stay 0. A load that clears the bit makes bursts work again.
- R12: rdata is 0 in every cycle where rdata_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write enable at burst start, active low |
| cre | input | 1 | Configuration-select, high for register load |
| ub_n | input | 1 | Upper byte enable, active low |
| lb_n | input | 1 | Lower byte enable, active low |
| addr | input | ADDR_W | Start address, or register value and select |
| wdata | input | 16 | Write data |
| refresh_req | input | 1 | Injected refresh pulse |
| rdata | output | 16 | Read data, 0 when not enabled |
| rdata_oe | output | 1 | Read data valid and driven |
| wait_o | output | 1 | Write hold-off, high while not ready |

## Verification
The bench first writes random data and then reads it back with lengths of 4, 8, 16 and continuous. It uses start addresses close to the end of a block, so a design that wraps wrongly returns words from the wrong place. Latency codes 0, 2, 4 and 7 are tried, and a counter that fails to clamp would move the first word or WAIT by a cycle. Refresh pulses are placed at the start of a write and in the middle of its latency. A design that ignores the stall would store the first word one or more cycles early. Further cases cover a configuration load in the middle of a burst, single-lane and no-lane traffic, a deselect in the middle of a burst, and deep power down. A wrong design would change the latency, write a disabled byte, or answer while powered down.

// File: rtl/psram_pkg.sv
package psram_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LAT, ST_DATA} burst_state_e;

  localparam int REG_SEL_BIT = 19;
  localparam int LEN_LSB     = 0;
  localparam int LAT_LSB     = 11;
  localparam int DPD_BIT     = 4;
  localparam logic [15:0] BUSCFG_RESET = 16'h1807;

  function automatic logic [2:0] clamp_latency(input logic [2:0] code);
    if (code < 3'd2) return 3'd2;
    if (code > 3'd6) return 3'd6;
    return code;
  endfunction
endpackage

// File: rtl/psram_cfg_regs.sv
module psram_cfg_regs
  import psram_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load_en,
  input  logic        sel_bus,
  input  logic [15:0] din,
  output logic [15:0] buscfg,
  output logic [15:0] pwrcfg,
  output logic [2:0]  lat_clks,
  output logic [2:0]  len_log2,
  output logic        len_cont,
  output logic        dpd
);
  logic [2:0] len_code;

  always_ff @(posedge clk) begin
    if (rst) begin
      buscfg <= BUSCFG_RESET;
      pwrcfg <= '0;
    end else if (load_en) begin
      if (sel_bus) buscfg <= din;
      else         pwrcfg <= din;
    end
  end

  assign len_code = buscfg[LEN_LSB +: 3];
  assign lat_clks = clamp_latency(buscfg[LAT_LSB +: 3]);
  assign dpd      = pwrcfg[DPD_BIT];

  always_comb begin
    len_cont = 1'b0;
    case (len_code)
      3'd1:    len_log2 = 3'd2;
      3'd2:    len_log2 = 3'd3;
      3'd3:    len_log2 = 3'd4;
      default: begin len_log2 = 3'd0; len_cont = 1'b1; end
    endcase
  end
endmodule

// File: rtl/psram_burst_ctrl.sv
module psram_burst_ctrl
  import psram_pkg::*;
#(
  parameter int AW         = 8,
  parameter int REF_CYCLES = 4,
  parameter int LEFT_W     = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          cre,
  input  logic          ub_n,
  input  logic          lb_n,
  input  logic [AW-1:0] start_addr,
  input  logic [2:0]    lat_clks,
  input  logic [2:0]    len_log2,
  input  logic          len_cont,
  input  logic          dpd,
  input  logic          refresh_req,
  output logic          busy,
  output logic          wait_o,
  output logic          ref_busy,
  output logic          rd_fire,
  output logic [1:0]    wr_en,
  output logic [AW-1:0] word_addr
);
  localparam int RW = $clog2(REF_CYCLES + 1);

  burst_state_e      state_q;
  logic [2:0]        cnt_q;
  logic              is_wr_q;
  logic              cont_q;
  logic [AW-1:0]     addr_q;
  logic [AW-1:0]     mask_q;
  logic [LEFT_W-1:0] left_q;
  logic [RW-1:0]     ref_q;

  logic deselect, start, step, beat;
  logic [AW-1:0] addr_inc, addr_nxt;

  assign deselect = cs_n | (ub_n & lb_n) | dpd;
  assign start    = ~deselect & ~adv_n & ~cre;
  assign step     = ~deselect & adv_n;
  assign beat     = step & (state_q == ST_DATA);
  assign ref_busy = (ref_q != '0);
  assign busy     = (state_q != ST_IDLE);
  assign wait_o   = (state_q == ST_LAT) & is_wr_q;
  assign rd_fire  = beat & ~is_wr_q;
  assign wr_en    = (beat & is_wr_q) ? ~{ub_n, lb_n} : 2'b00;
  assign word_addr = addr_q;

  assign addr_inc = addr_q + AW'(1);
  assign addr_nxt = cont_q ? addr_inc : ((addr_q & ~mask_q) | (addr_inc & mask_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
    end else if (ref_busy) begin
      ref_q <= ref_q - RW'(1);
    end else if (refresh_req) begin
      ref_q <= RW'(REF_CYCLES);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      is_wr_q <= 1'b0;
      cont_q  <= 1'b0;
      addr_q  <= '0;
      mask_q  <= '0;
      left_q  <= '0;
    end else if (deselect) begin
      state_q <= ST_IDLE;
    end else if (start) begin
      state_q <= ST_LAT;
      cnt_q   <= lat_clks - 3'd1;
      is_wr_q <= ~we_n;
      cont_q  <= len_cont;
      addr_q  <= start_addr;
      mask_q  <= len_cont ? '0 : AW'((32'd1 << len_log2) - 32'd1);
      left_q  <= LEFT_W'(32'd1 << len_log2);
    end else if (step) begin
      case (state_q)
        ST_LAT: begin
          if (!(is_wr_q && ref_busy)) begin
            if (cnt_q == 3'd1) state_q <= ST_DATA;
            else               cnt_q   <= cnt_q - 3'd1;
          end
        end
        ST_DATA: begin
          addr_q <= addr_nxt;
          if (!cont_q) begin
            left_q <= left_q - LEFT_W'(1);
            if (left_q == LEFT_W'(1)) state_q <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psram_mem_array.sv
module psram_mem_array #(
  parameter int AW    = 8,
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic [LANES-1:0]   we,
  input  logic [AW-1:0]      addr,
  input  logic [8*LANES-1:0] wdata,
  output logic [8*LANES-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] mem [0:DEPTH-1];
    always_ff @(posedge clk) begin
      if (we[g]) mem[addr] <= wdata[8*g +: 8];
      rdata[8*g +: 8] <= mem[addr];
    end
  end
endmodule

// File: rtl/psram_burst_front.sv
module psram_burst_front
  import psram_pkg::*;
#(
  parameter int ADDR_W     = 21,
  parameter int MEM_AW     = 8,
  parameter int REF_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              cre,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              refresh_req,
  output logic [15:0]       rdata,
  output logic              rdata_oe,
  output logic              wait_o
);
  localparam int LANES  = 2;
  localparam int LEFT_W = 5;

  logic [15:0] buscfg_w, pwrcfg_w, ram_q;
  logic [2:0]  lat_w, len_log2_w;
  logic        len_cont_w, dpd_w, ctrl_busy, ref_busy_w, rd_fire_w, load_en;
  logic [LANES-1:0]  wr_en_w, lane_q;
  logic [MEM_AW-1:0] word_addr_w;
  logic unused_addr_bits;

  assign unused_addr_bits = ^{addr[ADDR_W-1:REG_SEL_BIT+1], addr[REG_SEL_BIT-1:16]};
  assign load_en = ~cs_n & ~adv_n & cre & ~ctrl_busy;

  psram_cfg_regs i_cfg (
    .clk(clk), .rst(rst), .load_en(load_en), .sel_bus(addr[REG_SEL_BIT]),
    .din(addr[15:0]), .buscfg(buscfg_w), .pwrcfg(pwrcfg_w), .lat_clks(lat_w),
    .len_log2(len_log2_w), .len_cont(len_cont_w), .dpd(dpd_w)
  );

  psram_burst_ctrl #(.AW(MEM_AW), .REF_CYCLES(REF_CYCLES), .LEFT_W(LEFT_W)) i_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n), .cre(cre),
    .ub_n(ub_n), .lb_n(lb_n), .start_addr(addr[MEM_AW-1:0]), .lat_clks(lat_w),
    .len_log2(len_log2_w), .len_cont(len_cont_w), .dpd(dpd_w),
    .refresh_req(refresh_req), .busy(ctrl_busy), .wait_o(wait_o),
    .ref_busy(ref_busy_w), .rd_fire(rd_fire_w), .wr_en(wr_en_w), .word_addr(word_addr_w)
  );

  psram_mem_array #(.AW(MEM_AW), .LANES(LANES)) i_mem (
    .clk(clk), .we(wr_en_w), .addr(word_addr_w), .wdata(wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_oe <= 1'b0;
      lane_q   <= '0;
    end else begin
      rdata_oe <= rd_fire_w;
      lane_q   <= ~{ub_n, lb_n};
    end
  end

  assign rdata = rdata_oe ? (ram_q & {{8{lane_q[1]}}, {8{lane_q[0]}}}) : 16'h0000;
endmodule

// File: rtl/psram_front_checker.sv
module psram_front_checker (
  input logic        clk,
  input logic        rst,
  input logic        cs_n,
  input logic        adv_n,
  input logic        we_n,
  input logic        ub_n,
  input logic        lb_n,
  input logic        rdata_oe,
  input logic        wait_o,
  input logic        busy,
  input logic        dpd,
  input logic        ref_busy,
  input logic [15:0] buscfg,
  input logic [15:0] pwrcfg
);
  assert_cfg_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!$stable(buscfg) || !$stable(pwrcfg)) |-> $past(!busy && !cs_n && !adv_n));

  assert_wait_from_write_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_o) |-> $past(!cs_n && !adv_n && !we_n));

  assert_wait_no_read_R5: assert property (@(posedge clk) disable iff (rst)
    wait_o |-> !rdata_oe);

  assert_refresh_stall_R6: assert property (@(posedge clk) disable iff (rst)
    (wait_o && ref_busy && !cs_n && adv_n && !(ub_n && lb_n)) |=> wait_o);

  assert_lanes_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && ub_n && lb_n) |=> (!rdata_oe && !wait_o));

  assert_deselect_R8: assert property (@(posedge clk) disable iff (rst)
    cs_n |=> (!rdata_oe && !wait_o));

  assert_power_down_R11: assert property (@(posedge clk) disable iff (rst)
    dpd |=> (!rdata_oe && !wait_o));
endmodule

bind psram_burst_front psram_front_checker i_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n), .ub_n(ub_n),
  .lb_n(lb_n), .rdata_oe(rdata_oe), .wait_o(wait_o), .busy(ctrl_busy),
  .dpd(dpd_w), .ref_busy(ref_busy_w), .buscfg(buscfg_w), .pwrcfg(pwrcfg_w)
);

// File: tb/test_psram_burst_front.sv
`timescale 1ns/1ps
module test_psram_burst_front;
  localparam int REF = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, cre = 1'b0, ub_n = 1'b0, lb_n = 1'b0;
  logic [20:0] addr = '0;
  logic [15:0] wdata = '0;
  logic refresh_req = 1'b0;
  logic [15:0] rdata;
  logic rdata_oe, wait_o;

  always #5 clk = ~clk;

  psram_burst_front #(.ADDR_W(21), .MEM_AW(8), .REF_CYCLES(REF)) i_psram_burst_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n), .cre(cre),
    .ub_n(ub_n), .lb_n(lb_n), .addr(addr), .wdata(wdata), .refresh_req(refresh_req),
    .rdata(rdata), .rdata_oe(rdata_oe), .wait_o(wait_o)
  );

  int checks = 0, failures = 0, cycles = 0;
  string cur_req = "R1";
  bit comparing = 0;

  // behavioural reference model
  logic [7:0] mlo [0:255];
  logic [7:0] mhi [0:255];
  int m_state, m_cnt, m_addr, m_mask, m_left, m_ref, lat, lg;
  bit m_wr, m_cont, rb, desel;
  logic [15:0] m_bus, m_pwr, exp_rd;
  logic exp_oe, exp_wait;

  always @(posedge clk) begin
    if (rst) begin
      m_state = 0; m_ref = 0; m_bus = 16'h1807; m_pwr = 16'h0;
      exp_oe = 0; exp_wait = 0; exp_rd = 0;
    end else begin
      rb = (m_ref != 0);
      if (m_ref != 0) m_ref--; else if (refresh_req) m_ref = REF;
      desel = cs_n || (ub_n && lb_n) || m_pwr[4];
      exp_oe = 0; exp_rd = 0;
      if (!cs_n && !adv_n && cre && m_state == 0) begin
        if (addr[19]) m_bus = addr[15:0]; else m_pwr = addr[15:0];
      end
      if (desel) m_state = 0;
      else if (!adv_n && !cre) begin
        lat = int'(m_bus[13:11]);
        if (lat < 2) lat = 2;
        if (lat > 6) lat = 6;
        case (m_bus[2:0]) 3'd1: lg = 2; 3'd2: lg = 3; 3'd3: lg = 4; default: lg = 0; endcase
        m_cont = (lg == 0); m_mask = m_cont ? 0 : (1 << lg) - 1; m_left = 1 << lg;
        m_cnt = lat - 1; m_wr = !we_n; m_addr = int'(addr[7:0]); m_state = 1;
      end else if (!adv_n) begin
        // load attempt during a burst: burst frozen
      end else if (m_state == 1) begin
        if (!(m_wr && rb)) begin
          if (m_cnt == 1) m_state = 2; else m_cnt--;
        end
      end else if (m_state == 2) begin
        if (m_wr) begin
          if (!lb_n) mlo[m_addr] = wdata[7:0];
          if (!ub_n) mhi[m_addr] = wdata[15:8];
        end else begin
          exp_oe = 1;
          exp_rd = {ub_n ? 8'h00 : mhi[m_addr], lb_n ? 8'h00 : mlo[m_addr]};
        end
        if (m_cont) m_addr = (m_addr + 1) % 256;
        else m_addr = (m_addr & ~m_mask) | ((m_addr + 1) & m_mask);
        if (!m_cont) begin m_left--; if (m_left == 0) m_state = 0; end
      end
      exp_wait = (m_state == 1) && m_wr;
    end
  end

  always @(negedge clk) begin
    wdata <= 16'($urandom);
    if (comparing && !rst) begin
      checks++;
      if (rdata_oe !== exp_oe || wait_o !== exp_wait || rdata !== exp_rd) begin
        failures++;
        $display("FAIL %s t=%0t actual oe=%b wait=%b rdata=%h expected oe=%b wait=%b rdata=%h",
                 cur_req, $time, rdata_oe, wait_o, rdata, exp_oe, exp_wait, exp_rd);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic drv(input bit c, input bit a, input bit w, input bit r,
                     input bit u, input bit l, input int ad, input int n);
    for (int i = 0; i < n; i++) begin
      cs_n = c; adv_n = a; we_n = w; cre = r; ub_n = u; lb_n = l; addr = 21'(ad);
      @(negedge clk);
    end
  endtask

  task automatic start_burst(input bit wr, input int ad, input int beats);
    drv(0, 0, !wr, 0, 0, 0, ad, 1);
    drv(0, 1, 1, 0, 0, 0, 0, beats);
    drv(1, 1, 1, 0, 0, 0, 0, 2);
  endtask

  task automatic load_reg(input bit bus, input int val);
    drv(0, 0, 1, 1, 0, 0, (bus ? (1 << 19) : 0) | val, 1);
    drv(1, 1, 1, 0, 0, 0, 0, 1);
  endtask

  function automatic int buscode(input int latc, input int lenc);
    return (1 << 19) | (latc << 11) | lenc;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rdata_oe !== 1'b0 || wait_o !== 1'b0 || rdata !== 16'h0) begin
      failures++;
      $display("FAIL R1 reset actual oe=%b wait=%b rdata=%h expected 0 0 0000", rdata_oe, wait_o, rdata);
    end
    rst = 0;
    comparing = 1;
    @(negedge clk);

    cur_req = "R5"; start_burst(1, 8'h40, 10);          // default: continuous, latency 3
    cur_req = "R3"; start_burst(0, 8'h40, 10);
    cur_req = "R2"; load_reg(1, buscode(2, 1));          // length 4, latency 2
    cur_req = "R4"; start_burst(1, 8'h12, 6);
    start_burst(0, 8'h12, 9);
    cur_req = "R6"; load_reg(1, buscode(4, 2));          // length 8, latency 4
    refresh_req = 1; drv(0, 0, 0, 0, 0, 0, 8'h31, 1); refresh_req = 0;
    drv(0, 1, 1, 0, 0, 0, 0, 16); drv(1, 1, 1, 0, 0, 0, 0, 2);
    drv(0, 0, 0, 0, 0, 0, 8'h38, 1); drv(0, 1, 1, 0, 0, 0, 0, 1);
    refresh_req = 1; drv(0, 1, 1, 0, 0, 0, 0, 1); refresh_req = 0;
    drv(0, 1, 1, 0, 0, 0, 0, 16); drv(1, 1, 1, 0, 0, 0, 0, 2);
    cur_req = "R4"; start_burst(0, 8'h30, 14); start_burst(0, 8'h3D, 14);
    cur_req = "R7";
    drv(0, 0, 0, 0, 0, 0, 8'h33, 1); drv(0, 1, 1, 0, 1, 0, 0, 12); drv(1, 1, 1, 0, 0, 0, 0, 2);
    drv(0, 0, 1, 0, 0, 0, 8'h30, 1); drv(0, 1, 1, 0, 0, 1, 0, 12); drv(1, 1, 1, 0, 0, 0, 0, 2);
    drv(0, 0, 1, 0, 0, 0, 8'h30, 1); drv(0, 1, 1, 0, 0, 0, 0, 5);
    drv(0, 1, 1, 0, 1, 1, 0, 2); drv(0, 1, 1, 0, 0, 0, 0, 4); drv(1, 1, 1, 0, 0, 0, 0, 2);
    cur_req = "R8";
    drv(0, 0, 1, 0, 0, 0, 8'h30, 1); drv(0, 1, 1, 0, 0, 0, 0, 6);
    drv(1, 1, 1, 0, 0, 0, 0, 1); drv(0, 1, 1, 0, 0, 0, 0, 4); drv(1, 1, 1, 0, 0, 0, 0, 1);
    cur_req = "R9";
    drv(0, 0, 1, 0, 0, 0, 8'h30, 1); drv(0, 1, 1, 0, 0, 0, 0, 1);
    drv(0, 0, 1, 1, 0, 0, buscode(2, 1), 2);
    drv(0, 1, 1, 0, 0, 0, 0, 3);
    drv(0, 0, 1, 1, 0, 0, buscode(6, 3), 1);
    drv(0, 1, 1, 0, 0, 0, 0, 10); drv(1, 1, 1, 0, 0, 0, 0, 2);
    start_burst(0, 8'h31, 14);
    cur_req = "R10"; drv(0, 1, 1, 0, 0, 0, 8'h55, 6); drv(0, 1, 0, 0, 0, 0, 8'h55, 3);
    drv(1, 1, 1, 0, 0, 0, 0, 1);
    cur_req = "R11"; load_reg(0, 16'h0010);
    start_burst(0, 8'h30, 10); start_burst(1, 8'h30, 10);
    load_reg(0, 16'h0000);
    start_burst(0, 8'h30, 12);
    cur_req = "R3"; load_reg(1, buscode(7, 3));           // latency clamps to 6, length 16
    start_burst(1, 8'h80, 24); start_burst(0, 8'h8B, 24);
    load_reg(1, buscode(0, 3));                           // latency clamps to 2
    start_burst(0, 8'h85, 20);
    cur_req = "R4"; load_reg(1, buscode(3, 7));           // continuous, wraps the array
    start_burst(1, 8'hFC, 10); start_burst(0, 8'hFC, 10);
    cur_req = "R12"; drv(1, 1, 1, 0, 0, 0, 0, 4);

    comparing = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule